// File: doc/BRIEF.md
# Multi-Source Reset Sequencer

This block turns any of three reset requests into a single ordered reset sequence for a small processor core. The requests are an active-low external reset pin, a low-voltage flag and a watchdog expiry. A sequence has three phases. First comes an active phase whose length depends on the requester. Then comes a hold phase of 256 or 4096 clocks, chosen by a static option input, during which the pin is pulled low. Last comes a two-cycle vector fetch that presents the two bytes of the reset vector address, 16'hFFFE and then 16'hFFFF. The internal core reset stays high from the start of the active phase until the last fetch cycle.

The pin is bidirectional. The block senses it through a two-flop synchroniser and a minimum-width filter. It pulls the pin down through an open-drain enable, and while that enable is active its own pull-down is masked out of the sensing path. A sticky one-hot register records which requester started the most recent sequence. A read strobe clears it once the block is idle.

Top module: `rst_seq_ctrl`

## Requirements
- R1: The pin counts as a reset request only after it has been sampled low on at least MIN_W (default 4) consecutive clock edges. The sequence starts MIN_W+1 edges after the first low sample. A low pulse shorter than MIN_W clocks starts nothing.
- R2: The active phase lasts P-MIN_W+1 cycles for a pin request held low for P clocks. For the low-voltage flag it lasts as long as the flag stays high. For a watchdog pulse it lasts WDG_ACT cycles (default 8).
- R3: The hold phase lasts DLY_SHORT (256) cycles when long_dly_i is 0 and DLY_LONG (4096) cycles when it is 1.
- R4: pin_pull_o is high for the whole hold phase whatever the source, and during the active phase of the two internal sources. It is low during a pin-started active phase, during the fetch and when idle.
- R5: vec_fetch_o is high for exactly 2 cycles after the hold phase, with vec_addr_o = 16'hFFFE and then 16'hFFFF. vec_addr_o is 0 at all other times. core_rst_o is high from the start of the active phase through the last fetch cycle and falls right after it.
- R6: A low level on the pin while pin_pull_o is high is never taken as a new reset request.
- R7: A rising edge of lvd_i or wdg_i during any phase restarts the sequence from the active phase. core_rst_o stays high without a gap.
- R8: src_o is one-hot: bit 0 means pin, bit 1 low-voltage, bit 2 watchdog. It holds the source of the latest start or restart. If requests arrive on the same edge, low-voltage wins over pin, and pin wins over watchdog.
- R9: src_rd_i high on an edge while the block is idle clears src_o to 0 from the next cycle.
- R10: While rst is high, core_rst_o=1, pin_pull_o=1, vec_fetch_o=0 and src_o=0. After rst falls, a hold phase and a vector fetch follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Power-on reset, synchronous, active high |
| pin_n_i | input | 1 | Sensed level of the reset pin, active low |
| lvd_i | input | 1 | Low-voltage flag, high while supply is low |
| wdg_i | input | 1 | Watchdog expiry, rising edge requests a reset |
| long_dly_i | input | 1 | Static option: 0 short hold, 1 long hold |
| src_rd_i | input | 1 | Read strobe that clears the source record |
| pin_pull_o | output | 1 | Open-drain pull-down enable for the reset pin |
| core_rst_o | output | 1 | Internal reset level to the core |
| vec_fetch_o | output | 1 | High during the two vector-fetch cycles |
| vec_addr_o | output | 16 | Reset vector byte address during fetch, else 0 |
| src_o | output | 3 | Sticky one-hot record of the last reset source |

## Verification
Every output is decoded from registers. The bench therefore drives and samples on falling edges and counts the high cycles of core_rst_o, pin_pull_o and vec_fetch_o over a whole sequence, so it never needs the exact edge where a phase begins. The expected counts follow the timing in the requirements. A pin request starts MIN_W+1 edges after its first low sample and stays active until two edges after release. A low-voltage or watchdog request starts on the edge that sees it. The hold adds exactly 256 or 4096 cycles and the fetch adds 2. The source record is checked one falling edge after the sequence ends, and again one edge after a read strobe.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_ACTIVE,
        PH_HOLD,
        PH_FETCH
    } phase_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_PIN,
        SRC_LVD,
        SRC_WDG
    } src_e;

    typedef struct packed {
        logic pin;
        logic lvd;
        logic wdg;
    } req_s;

    localparam logic [15:0] VEC_ADDR_HI = 16'hFFFE;
    localparam logic [15:0] VEC_ADDR_LO = 16'hFFFF;

    // Low-voltage first, then pin, then watchdog
    function automatic src_e pick_src(req_s r);
        if (r.lvd)      return SRC_LVD;
        else if (r.pin) return SRC_PIN;
        else if (r.wdg) return SRC_WDG;
        else            return SRC_NONE;
    endfunction

    function automatic logic [2:0] src_onehot(src_e s);
        case (s)
            SRC_PIN: return 3'b001;
            SRC_LVD: return 3'b010;
            SRC_WDG: return 3'b100;
            default: return 3'b000;
        endcase
    endfunction

endpackage

// File: rtl/rsq_pin_filter.sv
module rsq_pin_filter #(
    parameter int MIN_W = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_i,
    input  logic mask_i,
    output logic low_o,
    output logic hit_o
);
    localparam int CW = $clog2(MIN_W + 1);

    logic          s1_q, s2_q;
    logic [CW-1:0] run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= 1'b0;
            s2_q  <= 1'b0;
            run_q <= '0;
        end else begin
            s1_q <= ~pin_n_i & ~mask_i;
            s2_q <= s1_q;
            if (!s2_q)
                run_q <= '0;
            else if (run_q != CW'(MIN_W))
                run_q <= run_q + 1'b1;
        end
    end

    assign low_o = s2_q;
    assign hit_o = s2_q && (run_q == CW'(MIN_W - 1));

endmodule

// File: rtl/rsq_req_detect.sv
module rsq_req_detect
    import rsq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic pin_hit_i,
    input  logic lvd_i,
    input  logic wdg_i,
    output logic start_o,
    output src_e src_o
);
    logic lvd_q, wdg_q;
    req_s req;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvd_q <= 1'b0;
            wdg_q <= 1'b0;
        end else begin
            lvd_q <= lvd_i;
            wdg_q <= wdg_i;
        end
    end

    always_comb begin
        req.pin = pin_hit_i;
        req.lvd = lvd_i & ~lvd_q;
        req.wdg = wdg_i & ~wdg_q;
    end

    assign start_o = |req;
    assign src_o   = pick_src(req);

endmodule

// File: rtl/rsq_phase_fsm.sv
module rsq_phase_fsm
    import rsq_pkg::*;
#(
    parameter int DLY_SHORT = 256,
    parameter int DLY_LONG  = 4096,
    parameter int WDG_ACT   = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start_i,
    input  src_e       start_src_i,
    input  logic       pin_low_i,
    input  logic       lvd_i,
    input  logic       long_i,
    input  logic       rd_i,
    output phase_e     phase_o,
    output src_e       cur_src_o,
    output logic       second_o,
    output logic [2:0] sticky_o
);
    localparam int DW = $clog2(DLY_LONG);

    phase_e        ph_q;
    src_e          cur_q;
    logic [DW-1:0] cnt_q;
    logic [2:0]    sticky_q;
    logic [DW-1:0] dly_last;
    logic          stay;

    assign dly_last = long_i ? DW'(DLY_LONG - 1) : DW'(DLY_SHORT - 1);

    always_comb begin
        case (cur_q)
            SRC_PIN: stay = pin_low_i;
            SRC_LVD: stay = lvd_i;
            SRC_WDG: stay = (cnt_q != DW'(WDG_ACT - 1));
            default: stay = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q     <= PH_HOLD;
            cur_q    <= SRC_NONE;
            cnt_q    <= '0;
            sticky_q <= '0;
        end else if (start_i) begin
            ph_q     <= PH_ACTIVE;
            cur_q    <= start_src_i;
            cnt_q    <= '0;
            sticky_q <= src_onehot(start_src_i);
        end else begin
            if (rd_i && ph_q == PH_IDLE)
                sticky_q <= '0;
            case (ph_q)
                PH_ACTIVE: begin
                    if (!stay) begin
                        ph_q  <= PH_HOLD;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_HOLD: begin
                    if (cnt_q == dly_last) begin
                        ph_q  <= PH_FETCH;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                PH_FETCH: begin
                    if (cnt_q[0]) begin
                        ph_q  <= PH_IDLE;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    assign phase_o   = ph_q;
    assign cur_src_o = cur_q;
    assign second_o  = cnt_q[0];
    assign sticky_o  = sticky_q;

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rsq_pkg::*;
#(
    parameter int MIN_W     = 4,
    parameter int DLY_SHORT = 256,
    parameter int DLY_LONG  = 4096,
    parameter int WDG_ACT   = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        pin_n_i,
    input  logic        lvd_i,
    input  logic        wdg_i,
    input  logic        long_dly_i,
    input  logic        src_rd_i,
    output logic        pin_pull_o,
    output logic        core_rst_o,
    output logic        vec_fetch_o,
    output logic [15:0] vec_addr_o,
    output logic [2:0]  src_o
);
    logic   pin_low, pin_hit, start, second;
    src_e   start_src, cur_src;
    phase_e phase;

    rsq_pin_filter #(.MIN_W(MIN_W)) filt_i (
        .clk     (clk),
        .rst     (rst),
        .pin_n_i (pin_n_i),
        .mask_i  (pin_pull_o),
        .low_o   (pin_low),
        .hit_o   (pin_hit)
    );

    rsq_req_detect det_i (
        .clk       (clk),
        .rst       (rst),
        .pin_hit_i (pin_hit),
        .lvd_i     (lvd_i),
        .wdg_i     (wdg_i),
        .start_o   (start),
        .src_o     (start_src)
    );

    rsq_phase_fsm #(
        .DLY_SHORT (DLY_SHORT),
        .DLY_LONG  (DLY_LONG),
        .WDG_ACT   (WDG_ACT)
    ) fsm_i (
        .clk         (clk),
        .rst         (rst),
        .start_i     (start),
        .start_src_i (start_src),
        .pin_low_i   (pin_low),
        .lvd_i       (lvd_i),
        .long_i      (long_dly_i),
        .rd_i        (src_rd_i),
        .phase_o     (phase),
        .cur_src_o   (cur_src),
        .second_o    (second),
        .sticky_o    (src_o)
    );

    assign core_rst_o  = (phase != PH_IDLE);
    assign pin_pull_o  = (phase == PH_HOLD) ||
                         (phase == PH_ACTIVE && cur_src != SRC_PIN);
    assign vec_fetch_o = (phase == PH_FETCH);
    assign vec_addr_o  = !vec_fetch_o ? 16'h0000 :
                         (second ? VEC_ADDR_LO : VEC_ADDR_HI);

endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk (
    input logic        clk,
    input logic        rst,
    input logic        pin_pull_o,
    input logic        core_rst_o,
    input logic        vec_fetch_o,
    input logic [15:0] vec_addr_o,
    input logic [2:0]  src_o
);
    // R5
    fetch_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        vec_fetch_o |-> core_rst_o);

    // R5
    fetch_first_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_fetch_o && !$past(vec_fetch_o)) |-> vec_addr_o == 16'hFFFE);

    // R5
    fetch_second_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (vec_fetch_o && $past(vec_fetch_o)) |-> vec_addr_o == 16'hFFFF);

    // R5
    addr_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !vec_fetch_o |-> vec_addr_o == 16'h0000);

    // R5
    core_release_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(core_rst_o) |-> $past(vec_fetch_o));

    // R4
    pull_in_reset_chk: assert property (@(posedge clk) disable iff (rst)
        pin_pull_o |-> core_rst_o);

    // R4
    pull_not_fetch_chk: assert property (@(posedge clk) disable iff (rst)
        !(pin_pull_o && vec_fetch_o));

    // R8
    src_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(src_o));

endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk chk_i (
    .clk         (clk),
    .rst         (rst),
    .pin_pull_o  (pin_pull_o),
    .core_rst_o  (core_rst_o),
    .vec_fetch_o (vec_fetch_o),
    .vec_addr_o  (vec_addr_o),
    .src_o       (src_o)
);

// File: tb/rst_seq_ctrl_tb_top.sv
module rst_seq_ctrl_tb_top;
    localparam int MIN_W = 4;
    localparam int DS    = 256;
    localparam int DL    = 4096;
    localparam int WACT  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ext_n = 1'b1;
    logic        lvd = 1'b0, wdg = 1'b0, long_dly = 1'b0, src_rd = 1'b0;
    logic        pin_n, pull, core_rst, fetch;
    logic [15:0] addr;
    logic [2:0]  src;

    int n_chk = 0, n_fail = 0, cyc = 0;
    int c_rst, c_pull, c_fetch;
    logic [15:0] a0, a1;
    logic mon_en = 1'b0;

    assign pin_n = ext_n & ~pull;

    always #5 clk = ~clk;

    rst_seq_ctrl dut_i (
        .clk(clk), .rst(rst), .pin_n_i(pin_n), .lvd_i(lvd), .wdg_i(wdg),
        .long_dly_i(long_dly), .src_rd_i(src_rd), .pin_pull_o(pull),
        .core_rst_o(core_rst), .vec_fetch_o(fetch), .vec_addr_o(addr),
        .src_o(src)
    );

    always @(negedge clk) begin
        if (mon_en) begin
            if (core_rst) c_rst++;
            if (pull) c_pull++;
            if (fetch) begin
                if (c_fetch == 0) a0 = addr; else a1 = addr;
                c_fetch++;
            end
        end
    end

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic mon_start();
        c_rst = 0; c_pull = 0; c_fetch = 0; a0 = 0; a1 = 0;
        mon_en = 1'b1;
    endtask

    task automatic wait_idle();
        repeat (8) @(negedge clk);
        for (int g = 0; g < 6000 && core_rst; g++) @(negedge clk);
        repeat (3) @(negedge clk);
        mon_en = 1'b0;
    endtask

    task automatic read_clear();
        @(negedge clk); src_rd = 1'b1;
        @(negedge clk); src_rd = 1'b0;
    endtask

    // kind 0 lvd, 1 watchdog, 2 pin; length; long option
    localparam int TBL [8][3] = '{
        '{0, 3, 0}, '{0, 1, 1}, '{1, 1, 0}, '{1, 1, 1},
        '{2, 4, 0}, '{2, 9, 0}, '{2, 3, 0}, '{2, 1, 0}
    };

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int d, e_rst, e_pull;
        logic [2:0] e_src;
        // R10 reset state
        repeat (3) @(negedge clk);
        chk("R10 core_rst", core_rst, 1);
        chk("R10 pull", pull, 1);
        chk("R10 fetch", fetch, 0);
        chk("R10 src", src, 0);
        mon_start();
        rst = 1'b0;
        wait_idle();
        chk("R10 fetch after reset", c_fetch, 2);
        chk("R10 idle", core_rst, 0);

        foreach (TBL[i]) begin
            long_dly = TBL[i][2][0];
            d = long_dly ? DL : DS;
            @(negedge clk);
            mon_start();
            case (TBL[i][0])
                0: begin
                    lvd = 1'b1; repeat (TBL[i][1]) @(negedge clk); lvd = 1'b0;
                    e_rst = TBL[i][1] + d + 2; e_pull = TBL[i][1] + d; e_src = 3'b010;
                end
                1: begin
                    wdg = 1'b1; @(negedge clk); wdg = 1'b0;
                    e_rst = WACT + d + 2; e_pull = WACT + d; e_src = 3'b100;
                end
                default: begin
                    ext_n = 1'b0; repeat (TBL[i][1]) @(negedge clk); ext_n = 1'b1;
                    if (TBL[i][1] >= MIN_W) begin
                        e_rst = TBL[i][1] - MIN_W + 1 + d + 2; e_pull = d; e_src = 3'b001;
                    end else begin
                        e_rst = 0; e_pull = 0; e_src = 3'b000;
                    end
                end
            endcase
            wait_idle();
            chk("R2 R3 core_rst length", c_rst, e_rst);
            chk("R4 pull length", c_pull, e_pull);
            chk("R1 R5 fetch cycles", c_fetch, e_rst > 0 ? 2 : 0);
            if (e_rst > 0) begin
                chk("R5 first addr", a0, 16'hFFFE);
                chk("R5 second addr", a1, 16'hFFFF);
            end
            chk("R8 source", src, e_src);
            read_clear();
            chk("R9 cleared", src, 0);
        end
        long_dly = 1'b0;

        // R7 restart by watchdog during hold
        @(negedge clk); mon_start();
        lvd = 1'b1; repeat (2) @(negedge clk); lvd = 1'b0;
        repeat (5) @(negedge clk); wdg = 1'b1;
        @(negedge clk); wdg = 1'b0;
        wait_idle();
        chk("R7 restart length", c_rst, 2 + 5 + WACT + DS + 2);
        chk("R7 single fetch", c_fetch, 2);
        chk("R7 R8 source", src, 3'b100);
        read_clear();

        // R8 same-edge priority
        @(negedge clk); mon_start();
        lvd = 1'b1; wdg = 1'b1;
        @(negedge clk); lvd = 1'b0; wdg = 1'b0;
        wait_idle();
        chk("R8 priority source", src, 3'b010);
        chk("R8 priority length", c_rst, 1 + DS + 2);
        read_clear();

        // R6 pin held low by other circuitry while block drives it
        @(negedge clk); mon_start();
        lvd = 1'b1; repeat (2) @(negedge clk); lvd = 1'b0;
        repeat (3) @(negedge clk); ext_n = 1'b0;
        repeat (10) @(negedge clk); ext_n = 1'b1;
        wait_idle();
        chk("R6 masked length", c_rst, 2 + DS + 2);
        chk("R6 masked source", src, 3'b010);

        // R9 read during a sequence does not clear
        @(negedge clk); wdg = 1'b1;
        @(negedge clk); wdg = 1'b0; src_rd = 1'b1;
        @(negedge clk); src_rd = 1'b0;
        chk("R9 no clear while busy", src, 3'b100);
        wait_idle();
        read_clear();
        chk("R9 clear when idle", src, 0);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule